// File: doc/BRIEF.md
# Zero-Cross Gated Update Controller

This block stands between a serial control receiver and the live control registers of an audio signal path. It decides in which cycle a newly received control word takes effect. Every received frame carries a two-bit gating code and a two-bit detection-point code next to its payload. The gating code picks one of two modes. In immediate mode the payload reaches the live registers at the load strobe. In zero-cross mode the payload is held back until a zero-crossing event arrives or a no-signal timeout ends.

The gating code and the detection point act in the same cycle as the load strobe. A single frame can therefore arm the detector at the right point in the signal path and also carry the payload that the detector gates. The zero-crossing comparator and the analog switches sit outside the block. The crossing event arrives as a one-cycle digital pulse from the point that `zc_point_o` names. The timeout length is a cycle count given with each load.

Top module: `zc_gate_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `live_o` equals the parameter RESET_DATA (default 0), `apply_o` is 0 and `zc_point_o` is 0.
- R2: A load with gating code 2'b11 (`mode_i[0]` is the first gating bit, `mode_i[1]` the second) writes `frame_i` to `live_o` at the clock edge that samples `load_i`. `apply_o` is 1 in the cycle that follows that edge.
- R3: The gating codes 2'b01 and 2'b10 also act as immediate mode, with the same timing as R2.
- R4: `zc_point_o` takes `point_i` at the edge that samples `load_i`, in every gating mode, and holds its value between loads. The codes are 0 for the input selector, 1 for the volume stage, 2 for the tone stage and 3 for the fader.
- R5: A load with gating code 2'b00 leaves `live_o` and `apply_o` unchanged. The held payload is applied at the first later edge that samples `zc_i` high.
- R6: When no crossing occurs, held data is applied at the edge that comes T edges after the load edge. T is `tmo_i` sampled at the load, and a value of 0 counts as 1.
- R7: A new zero-cross load while data is held replaces the held payload and restarts the timeout from the new load.
- R8: An immediate load while data is held applies the new payload at once and discards the held payload. No later apply follows from it.
- R9: `zc_i` has no effect when nothing is held, and it has no effect in a cycle in which `load_i` is high.
- R10: Each update raises `apply_o` for exactly one cycle, and `live_o` changes only in cycles in which `apply_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe marking that a received frame is complete |
| frame_i | input | DATA_W | Control payload of the frame |
| mode_i | input | 2 | Gating code; 2'b00 selects zero-cross mode |
| point_i | input | 2 | Detection-point code |
| tmo_i | input | TMO_W | No-signal timeout in cycles, sampled at load |
| zc_i | input | 1 | Zero-crossing pulse from the selected point |
| zc_point_o | output | 2 | Registered detection-point select |
| apply_o | output | 1 | Update strobe, one cycle per applied payload |
| live_o | output | DATA_W | Live control word |

## Verification
The bench builds the block with DATA_W=16 and TMO_W=8. The narrow timeout counter lets short timeouts of 0, 1, 7 and 10 cycles be counted edge by edge, and lets a long 50-cycle timeout be cancelled by a crossing and then shown never to fire. With the 16-bit payload, each scenario can use a distinct word, so a replaced or discarded payload that reaches `live_o` shows up at once.

// File: rtl/zc_gate_pkg.sv
package zc_gate_pkg;

  typedef enum logic [1:0] {
    PT_SELECTOR = 2'd0,
    PT_VOLUME   = 2'd1,
    PT_TONE     = 2'd2,
    PT_FADER    = 2'd3
  } zc_point_e;

  typedef enum logic [1:0] {
    GATE_ZC    = 2'b00,
    GATE_IMM_A = 2'b01,
    GATE_IMM_B = 2'b10,
    GATE_IMM   = 2'b11
  } gate_mode_e;

endpackage

// File: rtl/zc_mode_dec.sv
module zc_mode_dec
  import zc_gate_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] point_i,
  output logic       imm_o,
  output zc_point_e  point_o
);

  gate_mode_e mode;

  always_comb begin
    mode = gate_mode_e'(mode_i);
    // only the all-zero code gates on a crossing
    imm_o   = (mode != GATE_ZC);
    point_o = zc_point_e'(point_i);
  end

endmodule

// File: rtl/zc_tmo_timer.sv
module zc_tmo_timer #(
  parameter int TMO_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [TMO_W-1:0] len_i,
  output logic             expire_o
);

  logic [TMO_W-1:0] cnt_q;
  logic             last_step;

  // a count of 0 or 1 means this edge is the last one
  assign last_step = (cnt_q[TMO_W-1:1] == '0);
  assign expire_o  = active_i && !start_i && last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= len_i;
    end else if (active_i && !last_step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/zc_hold_regs.sv
module zc_hold_regs #(
  parameter int              DATA_W     = 36,
  parameter logic [DATA_W-1:0] RESET_DATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              imm_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic              fire_i,
  output logic              held_o,
  output logic              apply_o,
  output logic [DATA_W-1:0] live_o
);

  logic [DATA_W-1:0] held_q;
  logic              held_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= '0;
      held_v_q <= 1'b0;
      live_o   <= RESET_DATA;
      apply_o  <= 1'b0;
    end else if (load_i) begin
      if (imm_i) begin
        live_o   <= frame_i;
        apply_o  <= 1'b1;
        held_v_q <= 1'b0;
      end else begin
        held_q   <= frame_i;
        held_v_q <= 1'b1;
        apply_o  <= 1'b0;
      end
    end else if (held_v_q && fire_i) begin
      live_o   <= held_q;
      apply_o  <= 1'b1;
      held_v_q <= 1'b0;
    end else begin
      apply_o  <= 1'b0;
    end
  end

  assign held_o = held_v_q;

endmodule

// File: rtl/zc_gate_ctrl.sv
module zc_gate_ctrl
  import zc_gate_pkg::*;
#(
  parameter int                DATA_W     = 36,
  parameter int                TMO_W      = 24,
  parameter logic [DATA_W-1:0] RESET_DATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        point_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              zc_i,
  output logic [1:0]        zc_point_o,
  output logic              apply_o,
  output logic [DATA_W-1:0] live_o
);

  logic      imm;
  zc_point_e point_dec;
  zc_point_e point_q;
  logic      held;
  logic      expire;
  logic      fire;

  zc_mode_dec u_dec (
    .mode_i  (mode_i),
    .point_i (point_i),
    .imm_o   (imm),
    .point_o (point_dec)
  );

  // detection point acts at once, ahead of the payload it gates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     point_q <= PT_SELECTOR;
    else if (load_i) point_q <= point_dec;
  end

  assign zc_point_o = point_q;

  zc_tmo_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (load_i && !imm),
    .active_i (held),
    .len_i    (tmo_i),
    .expire_o (expire)
  );

  assign fire = zc_i || expire;

  zc_hold_regs #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .imm_i   (imm),
    .frame_i (frame_i),
    .fire_i  (fire),
    .held_o  (held),
    .apply_o (apply_o),
    .live_o  (live_o)
  );

endmodule

// File: rtl/zc_gate_ctrl_chk.sv
module zc_gate_ctrl_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [DATA_W-1:0] frame_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        point_i,
  input logic [1:0]        zc_point_o,
  input logic              apply_o,
  input logic [DATA_W-1:0] live_o
);

  AST_IMM_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i != 2'b00) |=> (apply_o && live_o == $past(frame_i))); // R2

  AST_POINT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (zc_point_o == $past(point_i))); // R4

  AST_POINT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(zc_point_o)); // R4

  AST_ZC_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == 2'b00) |=> !apply_o); // R5

  AST_LIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_o |-> $stable(live_o)); // R10

endmodule

bind zc_gate_ctrl zc_gate_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .frame_i    (frame_i),
  .mode_i     (mode_i),
  .point_i    (point_i),
  .zc_point_o (zc_point_o),
  .apply_o    (apply_o),
  .live_o     (live_o)
);

// File: tb/zc_gate_ctrl_tb.sv
module zc_gate_ctrl_tb;

  localparam int DATA_W = 16;
  localparam int TMO_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [DATA_W-1:0] frame_i = '0;
  logic [1:0]        mode_i = '0;
  logic [1:0]        point_i = '0;
  logic [TMO_W-1:0]  tmo_i = '0;
  logic              zc_i = 1'b0;
  logic [1:0]        zc_point_o;
  logic              apply_o;
  logic [DATA_W-1:0] live_o;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] exp_live = '0;

  always #4 clk_i = ~clk_i;

  zc_gate_ctrl #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .frame_i(frame_i),
    .mode_i(mode_i), .point_i(point_i), .tmo_i(tmo_i), .zc_i(zc_i),
    .zc_point_o(zc_point_o), .apply_o(apply_o), .live_o(live_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns half a cycle after the edge that sampled the load
  task automatic do_load(input logic [1:0] m, input logic [1:0] p,
                         input logic [DATA_W-1:0] f, input logic [TMO_W-1:0] t,
                         input logic with_zc);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = m; point_i = p; frame_i = f; tmo_i = t; zc_i = with_zc;
    @(negedge clk_i);
    load_i = 1'b0; zc_i = 1'b0;
  endtask

  task automatic pulse_zc();
    @(negedge clk_i);
    zc_i = 1'b1;
    @(negedge clk_i);
    zc_i = 1'b0;
  endtask

  // number of edges until apply_o is seen, 0 if none within lim
  task automatic wait_apply(input int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk_i);
      if (apply_o) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 live", live_o, '0);
    chk("R1 apply", apply_o, 0);
    chk("R1 point", zc_point_o, 0);
  endtask

  task automatic t_imm();
    do_load(2'b11, 2'd0, 16'hA5A5, 8'd20, 1'b0);
    chk("R2 live", live_o, 16'hA5A5);
    chk("R2 apply", apply_o, 1);
    @(negedge clk_i);
    chk("R10 apply one cycle", apply_o, 0);
    exp_live = 16'hA5A5;
  endtask

  task automatic t_imm_odd();
    do_load(2'b01, 2'd0, 16'h1111, 8'd20, 1'b0);
    chk("R3 code01 live", live_o, 16'h1111);
    chk("R3 code01 apply", apply_o, 1);
    do_load(2'b10, 2'd0, 16'h2222, 8'd20, 1'b0);
    chk("R3 code10 live", live_o, 16'h2222);
    chk("R3 code10 apply", apply_o, 1);
    exp_live = 16'h2222;
  endtask

  task automatic t_point();
    do_load(2'b11, 2'd1, 16'h3333, 8'd20, 1'b0);
    chk("R4 volume", zc_point_o, 1);
    do_load(2'b11, 2'd2, 16'h3334, 8'd20, 1'b0);
    chk("R4 tone", zc_point_o, 2);
    // zero-cross load: point changes before the payload lands
    do_load(2'b00, 2'd3, 16'h4444, 8'd3, 1'b0);
    chk("R4 fader at load", zc_point_o, 3);
    chk("R5 live held", live_o, 16'h3334);
    repeat (4) @(negedge clk_i);
    chk("R4 point held", zc_point_o, 3);
    do_load(2'b11, 2'd0, 16'h4445, 8'd20, 1'b0);
    chk("R4 selector", zc_point_o, 0);
    exp_live = 16'h4445;
  endtask

  task automatic t_zc();
    int n;
    do_load(2'b00, 2'd1, 16'hBEEF, 8'd50, 1'b0);
    repeat (5) @(negedge clk_i);
    chk("R5 no apply before crossing", apply_o, 0);
    chk("R5 live unchanged", live_o, exp_live);
    pulse_zc();
    chk("R5 apply on crossing", apply_o, 1);
    chk("R5 live after crossing", live_o, 16'hBEEF);
    exp_live = 16'hBEEF;
    wait_apply(60, n);
    chk("R10 no second apply", n, 0);
  endtask

  task automatic t_tmo();
    int n;
    do_load(2'b00, 2'd0, 16'h0707, 8'd7, 1'b0);
    wait_apply(20, n);
    chk("R6 timeout 7", n, 7);
    chk("R6 live after timeout", live_o, 16'h0707);
    do_load(2'b00, 2'd0, 16'h0101, 8'd1, 1'b0);
    wait_apply(20, n);
    chk("R6 timeout 1", n, 1);
    do_load(2'b00, 2'd0, 16'h0000 | 16'h00F0, 8'd0, 1'b0);
    wait_apply(20, n);
    chk("R6 timeout 0", n, 1);
    chk("R6 live zero len", live_o, 16'h00F0);
    exp_live = 16'h00F0;
  endtask

  task automatic t_replace();
    int n;
    do_load(2'b00, 2'd0, 16'hC0C0, 8'd10, 1'b0);
    wait_apply(4, n);
    chk("R7 none before replace", n, 0);
    do_load(2'b00, 2'd0, 16'hD0D0, 8'd10, 1'b0);
    wait_apply(20, n);
    chk("R7 restart count", n, 10);
    chk("R7 replaced data", live_o, 16'hD0D0);
    exp_live = 16'hD0D0;
  endtask

  task automatic t_cancel();
    int n;
    do_load(2'b00, 2'd0, 16'hE0E0, 8'd5, 1'b0);
    repeat (2) @(negedge clk_i);
    do_load(2'b11, 2'd0, 16'hF0F0, 8'd5, 1'b0);
    chk("R8 immediate wins", live_o, 16'hF0F0);
    chk("R8 apply", apply_o, 1);
    wait_apply(12, n);
    chk("R8 held discarded", n, 0);
    chk("R8 live kept", live_o, 16'hF0F0);
    exp_live = 16'hF0F0;
  endtask

  task automatic t_zc_idle();
    int n;
    pulse_zc();
    chk("R9 idle crossing apply", apply_o, 0);
    chk("R9 idle crossing live", live_o, exp_live);
    do_load(2'b00, 2'd0, 16'h5A5A, 8'd6, 1'b1);
    chk("R9 crossing at load", apply_o, 0);
    chk("R9 live at load", live_o, exp_live);
    wait_apply(20, n);
    chk("R9 timeout after ignored crossing", n, 6);
    chk("R9 live final", live_o, 16'h5A5A);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_imm();
    t_imm_odd();
    t_point();
    t_zc();
    t_tmo();
    t_replace();
    t_cancel();
    t_zc_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule